// File: doc/BRIEF.md
# Interrupt Priority and Acknowledge Unit

This block keeps the interrupt state of one local interrupt controller. Three 256-entry bitmaps hold it: requests waiting for service, vectors in service, and the trigger mode of each vector. Beside them sit an 8-bit task priority and a processor priority derived from it. Incoming vectors enter through an accept port, which flags a request that duplicates one already pending. The processor takes the highest deliverable vector through an acknowledge handshake. It retires the most urgent in-service vector with an end-of-interrupt strobe.

Vector numbers 0 to 15 are reserved. When such a vector is the most urgent pending request, the unit presents a statically configured error vector in its place and records the event in an error status byte. Software-visible state leaves the block through plain read ports: a word-select read of any bitmap, plus the task priority, processor priority and error status.

Top module: `irq_prio_unit`

## Requirements
- R1: After synchronous reset all three bitmaps, the task priority, the processor priority and the error status are zero, and `intr_pending` is low.
- R2: An accepted vector whose request bit is clear sets that request bit. Its trigger bit becomes `acc_level` (1 = level, 0 = edge). If the request bit is already set, `acc_dropped` is high in that cycle and the request and trigger bitmaps are left unchanged.
- R3: The processor priority equals the task priority when task priority bits 7:4 are at least bits 7:4 of the highest in-service vector (taken as 0 when nothing is in service). Otherwise it is those in-service bits 7:4 followed by four zero bits.
- R4: `intr_pending` is high exactly when some request bit is set and the highest set request vector is greater than or equal to the processor priority. `intr_vector` then shows that vector.
- R5: On a clock edge with `ack_req` and `intr_pending` both high, the presented vector leaves the request bitmap and enters the in-service bitmap. `ack_req` with `intr_pending` low changes nothing.
- R6: When the highest pending request is below 16 and deliverable, `intr_vector` equals `err_vector`. Acknowledging it clears the reserved request bit, sets the `err_vector` in-service bit and sets error status bit 5 (value 0x20), which stays set.
- R7: `eoi_we` clears the highest set in-service bit and the trigger bit of that vector, and the processor priority follows at once. With nothing in service the strobe changes nothing.
- R8: A `tpr_we` write stores only `tpr_wdata[7:0]` as the task priority.
- R9: `rd_data` shows bits 32*w+31 down to 32*w of the bitmap chosen by `rd_sel`, where w is `rd_word` (0 = request, 1 = in-service, 2 = trigger, 3 = reads zero). Vector v sits in word v/32, bit v%32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Incoming vector strobe |
| acc_vector | input | 8 | Incoming vector number |
| acc_level | input | 1 | Incoming vector is level-triggered |
| acc_dropped | output | 1 | Incoming vector duplicates a pending request |
| ack_req | input | 1 | Processor takes the presented vector |
| intr_pending | output | 1 | A deliverable vector is presented |
| intr_vector | output | 8 | Presented vector |
| eoi_we | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write strobe |
| tpr_wdata | input | 32 | Task priority write data |
| err_vector | input | 8 | Static error vector |
| rd_sel | input | 2 | Bitmap select for reads |
| rd_word | input | 3 | Word select for reads |
| rd_data | output | 32 | Selected bitmap word |
| tpr_o | output | 8 | Task priority |
| ppr_o | output | 8 | Processor priority |
| esr_o | output | 8 | Error status |

## Verification
Single edge and level requests check both the trigger bits and the duplicate flag. A request held back by an in-service vector of higher class is released by end-of-interrupt. This separates gating by the in-service class from gating by task priority. Two task priority values are set on either side of a pending vector's class (0x35 against 0x80, 0xA5 against 0x80), which exercises both branches of the priority derivation. The pending-versus-priority comparison is probed at equality (0x40 against 0x40 and 0x41). A reserved vector, nested in-service vectors and end-of-interrupt on an empty in-service map cover the substitution, the highest-bit retirement order and the ignored strobe.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NVEC       = 256;
    localparam int VEC_W      = $clog2(NVEC);
    localparam int WORD_W     = 32;
    localparam int NWORD      = NVEC / WORD_W;
    localparam int WSEL_W     = $clog2(NWORD);
    localparam int RSV_LIMIT  = 16;
    localparam int ESR_W      = 8;
    localparam int ESR_RSV    = 5;
    localparam int CLASS_LSB  = 4;

    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [1:0] {
        MAP_REQ  = 2'd0,
        MAP_SVC  = 2'd1,
        MAP_TRIG = 2'd2,
        MAP_NONE = 2'd3
    } map_sel_e;

    typedef struct packed {
        logic valid;
        vec_t idx;
    } hit_t;

    function automatic vec_t derive_ppr(vec_t tpr, hit_t svc);
        logic [VEC_W-CLASS_LSB-1:0] tcls, scls;
        tcls = tpr[VEC_W-1:CLASS_LSB];
        scls = svc.valid ? svc.idx[VEC_W-1:CLASS_LSB] : '0;
        if (tcls >= scls) return tpr;
        return {scls, {CLASS_LSB{1'b0}}};
    endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int WIDTH = 256,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (bits[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ppr_calc.sv
module irq_ppr_calc
    import irq_pkg::*;
(
    input  vec_t tpr,
    input  hit_t svc_hit,
    output vec_t ppr
);
    always_comb ppr = derive_ppr(tpr, svc_hit);
endmodule

// File: rtl/irq_map_read.sv
module irq_map_read
    import irq_pkg::*;
(
    input  logic [NVEC-1:0]   req_map,
    input  logic [NVEC-1:0]   svc_map,
    input  logic [NVEC-1:0]   trig_map,
    input  logic [1:0]        sel,
    input  logic [WSEL_W-1:0] word,
    output logic [WORD_W-1:0] data
);
    logic [WORD_W-1:0] req_w [NWORD];
    logic [WORD_W-1:0] svc_w [NWORD];
    logic [WORD_W-1:0] trig_w[NWORD];

    for (genvar g = 0; g < NWORD; g++) begin : g_slice
        assign req_w[g]  = req_map[g*WORD_W +: WORD_W];
        assign svc_w[g]  = svc_map[g*WORD_W +: WORD_W];
        assign trig_w[g] = trig_map[g*WORD_W +: WORD_W];
    end

    always_comb begin
        unique case (map_sel_e'(sel))
            MAP_REQ:  data = req_w[word];
            MAP_SVC:  data = svc_w[word];
            MAP_TRIG: data = trig_w[word];
            default:  data = '0;
        endcase
    end
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
    import irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        acc_valid,
    input  logic [7:0]  acc_vector,
    input  logic        acc_level,
    output logic        acc_dropped,
    input  logic        ack_req,
    output logic        intr_pending,
    output logic [7:0]  intr_vector,
    input  logic        eoi_we,
    input  logic        tpr_we,
    input  logic [31:0] tpr_wdata,
    input  logic [7:0]  err_vector,
    input  logic [1:0]  rd_sel,
    input  logic [2:0]  rd_word,
    output logic [31:0] rd_data,
    output logic [7:0]  tpr_o,
    output logic [7:0]  ppr_o,
    output logic [7:0]  esr_o
);
    logic [NVEC-1:0]  req_q, svc_q, trig_q;
    logic [NVEC-1:0]  req_n, svc_n, trig_n;
    vec_t             tpr_q, tpr_n;
    logic [ESR_W-1:0] esr_q, esr_n;

    hit_t req_hit, svc_hit;
    vec_t ppr;
    logic deliverable, reserved, ack_fire, acc_take, eoi_fire;
    vec_t shown;

    irq_prio_enc #(.WIDTH(NVEC)) u_req_enc (
        .bits(req_q), .valid(req_hit.valid), .idx(req_hit.idx));
    irq_prio_enc #(.WIDTH(NVEC)) u_svc_enc (
        .bits(svc_q), .valid(svc_hit.valid), .idx(svc_hit.idx));

    irq_ppr_calc u_ppr (.tpr(tpr_q), .svc_hit(svc_hit), .ppr(ppr));

    irq_map_read u_rd (
        .req_map(req_q), .svc_map(svc_q), .trig_map(trig_q),
        .sel(rd_sel), .word(rd_word), .data(rd_data));

    always_comb begin
        deliverable = req_hit.valid && (req_hit.idx >= ppr);
        reserved    = req_hit.idx < vec_t'(RSV_LIMIT);
        shown       = reserved ? err_vector : req_hit.idx;
        ack_fire    = ack_req && deliverable;
        acc_take    = acc_valid && !req_q[acc_vector];
        eoi_fire    = eoi_we && svc_hit.valid;
    end

    always_comb begin
        req_n  = req_q;
        svc_n  = svc_q;
        trig_n = trig_q;
        esr_n  = esr_q;
        tpr_n  = tpr_q;
        if (ack_fire) begin
            req_n[req_hit.idx] = 1'b0;
            req_n[shown]       = 1'b0;
            svc_n[shown]       = 1'b1;
            if (reserved) esr_n[ESR_RSV] = 1'b1;
        end
        if (eoi_fire) begin
            svc_n[svc_hit.idx]  = 1'b0;
            trig_n[svc_hit.idx] = 1'b0;
        end
        if (acc_take) begin
            req_n[acc_vector]  = 1'b1;
            trig_n[acc_vector] = acc_level;
        end
        if (tpr_we) tpr_n = tpr_wdata[VEC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            svc_q  <= '0;
            trig_q <= '0;
            tpr_q  <= '0;
            esr_q  <= '0;
        end else begin
            req_q  <= req_n;
            svc_q  <= svc_n;
            trig_q <= trig_n;
            tpr_q  <= tpr_n;
            esr_q  <= esr_n;
        end
    end

    assign acc_dropped  = acc_valid && req_q[acc_vector];
    assign intr_pending = deliverable;
    assign intr_vector  = shown;
    assign tpr_o        = tpr_q;
    assign ppr_o        = ppr;
    assign esr_o        = esr_q;
endmodule

// File: rtl/irq_prio_unit_chk.sv
module irq_prio_unit_chk
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            acc_valid,
    input logic [7:0]      acc_vector,
    input logic            acc_dropped,
    input logic            ack_req,
    input logic            intr_pending,
    input logic [7:0]      intr_vector,
    input logic            eoi_we,
    input logic            tpr_we,
    input logic [31:0]     tpr_wdata,
    input logic [7:0]      tpr,
    input logic [7:0]      ppr,
    input logic [NVEC-1:0] req,
    input logic [NVEC-1:0] svc
);
    // R3
    ppr_floor_chk: assert property (@(posedge clk) disable iff (rst)
        ppr >= tpr);

    // R3
    ppr_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (ppr[3:0] != 4'd0) |-> (ppr == tpr));

    // R5
    ack_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_req && intr_pending) |=> svc[$past(intr_vector)]);

    // R2
    accept_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_dropped) |=> req[$past(acc_vector)]);

    // R7
    eoi_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (eoi_we && !ack_req && svc == '0) |=> (svc == '0));

    // R8
    tpr_write_chk: assert property (@(posedge clk) disable iff (rst)
        tpr_we |=> (tpr == $past(tpr_wdata[7:0])));
endmodule

bind irq_prio_unit irq_prio_unit_chk i_chk (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_vector(acc_vector),
    .acc_dropped(acc_dropped), .ack_req(ack_req), .intr_pending(intr_pending),
    .intr_vector(intr_vector), .eoi_we(eoi_we), .tpr_we(tpr_we),
    .tpr_wdata(tpr_wdata), .tpr(tpr_o), .ppr(ppr_o), .req(req_q), .svc(svc_q));

// File: tb/test_irq_prio_unit.sv
module test_irq_prio_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_level = 1'b0, ack_req = 1'b0;
    logic        eoi_we = 1'b0, tpr_we = 1'b0;
    logic [7:0]  acc_vector = '0;
    logic [31:0] tpr_wdata = '0;
    logic [7:0]  err_vector = 8'hFE;
    logic [1:0]  rd_sel = '0;
    logic [2:0]  rd_word = '0;
    logic        acc_dropped, intr_pending;
    logic [7:0]  intr_vector, tpr_o, ppr_o, esr_o;
    logic [31:0] rd_data;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    irq_prio_unit i_irq_prio_unit (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic accept(logic [7:0] v, logic lvl);
        acc_valid = 1'b1; acc_vector = v; acc_level = lvl;
        tick();
        acc_valid = 1'b0;
    endtask

    task automatic take(logic [7:0] exp_v);
        exp_q.push_back(exp_v);
        ack_req = 1'b1;
        tick();
        ack_req = 1'b0;
    endtask

    task automatic eoi();
        eoi_we = 1'b1; tick(); eoi_we = 1'b0;
    endtask

    task automatic set_tpr(logic [31:0] d);
        tpr_we = 1'b1; tpr_wdata = d; tick(); tpr_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, logic [2:0] w, output logic [31:0] d);
        rd_sel = s; rd_word = w; #1; d = rd_data;
    endtask

    // scoreboard monitor: each acknowledge pops the expected vector
    always @(negedge clk) begin
        if (!rst && ack_req && intr_pending) begin
            if (exp_q.size() == 0) check("R5 unexpected ack", {24'd0, intr_vector}, 32'hFFFF_FFFF);
            else check("R4 delivered vector", {24'd0, intr_vector}, {24'd0, exp_q.pop_front()});
        end
    end

    initial begin
        #100000;
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        tick(); tick();
        rst = 1'b0;
        // R1 reset state
        check("R1 pending", {31'd0, intr_pending}, 0);
        check("R1 ppr", {24'd0, ppr_o}, 0);
        check("R1 esr", {24'd0, esr_o}, 0);
        rd(0, 2, d); check("R1 req map", d, 0);

        // R2 edge accept, then duplicate
        accept(8'h45, 1'b0);
        rd(0, 2, d); check("R9 R2 req word2", d, 32'h20);
        acc_valid = 1'b1; acc_vector = 8'h45; acc_level = 1'b1; #1;
        check("R2 dropped", {31'd0, acc_dropped}, 1);
        tick(); acc_valid = 1'b0;
        rd(2, 2, d); check("R2 dup leaves trig", d, 0);
        accept(8'h80, 1'b1);
        rd(2, 4, d); check("R2 level trig", d, 32'h1);

        // R4 R5 acknowledge highest
        check("R4 pending", {31'd0, intr_pending}, 1);
        take(8'h80);
        rd(1, 4, d); check("R5 svc set", d, 32'h1);
        rd(0, 4, d); check("R5 req cleared", d, 0);
        check("R3 ppr from class", {24'd0, ppr_o}, 32'h80);
        check("R4 gated", {31'd0, intr_pending}, 0);

        // R3 R8 task priority branches
        set_tpr(32'h0000_01A5);
        check("R8 tpr bits", {24'd0, tpr_o}, 32'hA5);
        check("R3 tpr wins", {24'd0, ppr_o}, 32'hA5);
        set_tpr(32'h35);
        check("R3 class wins", {24'd0, ppr_o}, 32'h80);

        // R7 EOI retires and clears trig
        eoi();
        rd(2, 4, d); check("R7 trig cleared", d, 0);
        check("R7 ppr follows", {24'd0, ppr_o}, 32'h35);
        check("R4 released", {31'd0, intr_pending}, 1);
        take(8'h45);
        check("R3 ppr 0x40", {24'd0, ppr_o}, 32'h40);
        eoi();
        eoi();
        rd(1, 2, d); check("R7 empty eoi", d, 0);
        check("R7 empty ppr", {24'd0, ppr_o}, 32'h35);

        // R6 reserved vector
        set_tpr(0);
        accept(8'h05, 1'b0);
        check("R6 substituted", {24'd0, intr_vector}, 32'hFE);
        take(8'hFE);
        check("R6 esr", {24'd0, esr_o}, 32'h20);
        rd(1, 7, d); check("R6 svc err", d, 32'h4000_0000);
        rd(0, 0, d); check("R6 reserved cleared", d, 0);

        // nesting
        accept(8'h30, 1'b0);
        check("R4 blocked by F0", {31'd0, intr_pending}, 0);
        eoi();
        take(8'h30);
        accept(8'h50, 1'b0);
        take(8'h50);
        eoi();
        rd(1, 1, d); check("R7 lower stays", d, 32'h0001_0000);
        rd(1, 2, d); check("R7 highest gone", d, 0);
        check("R3 ppr 0x30", {24'd0, ppr_o}, 32'h30);
        eoi();

        // R4 equality boundary
        set_tpr(32'h40);
        accept(8'h40, 1'b0);
        check("R4 equal", {31'd0, intr_pending}, 1);
        set_tpr(32'hDEAD_BE41);
        check("R8 low byte", {24'd0, tpr_o}, 32'h41);
        check("R4 below", {31'd0, intr_pending}, 0);
        ack_req = 1'b1; tick(); ack_req = 1'b0;
        rd(0, 2, d); check("R5 ignored ack", d, 32'h1);
        rd(3, 2, d); check("R9 none sel", d, 0);
        check("R6 esr sticky", {24'd0, esr_o}, 32'h20);
        check("R5 queue drained", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule